// File: doc/BRIEF.md
# Single-Wire Debug Target Bit Engine

This block is the target-side bit engine for a one-wire, pseudo-open-drain debug line. It runs on the target's bus clock. The host starts every bit cell by pulling the line low. The engine brings the line into the clock domain and detects that falling edge, which marks the perceived start of the cell. From there it either samples the level the host left on the line, or drives the line to return a bit the host asked for.

The pad appears as three plain signals: an output enable, an output value and the pad input. A weak external pull-up is assumed. A bit to send is loaded only while the engine is idle, and it is used in the next cell the host starts. A logic 0 is returned by holding the line low. A logic 1 is returned by leaving the line undriven and then firing a one-cycle active-high speed-up pulse. A received bit is handed out with a one-cycle valid strobe. Commands, byte framing and memory access belong to the layers above.

Edge numbering used below: edge 1 is the first rising clock edge at which `line_in` is registered low after being high in an idle engine. "After edge k" means the cycle that follows edge k.

Top module: `dbgl_bit_engine`

## Requirements
- R1: After reset, line_oe and rx_valid are 0 and tx_ready is 1.
- R2: In a receive cell, rx_valid is 1 for exactly one cycle, after edge 13, and is 0 in every other cycle of the cell.
- R3: Together with that strobe, rx_bit equals the line_in level registered at edge 11.
- R4: In a receive cell the engine never drives the line: line_oe stays 0.
- R5: tx_ready is 1 only when no cell is in progress, no bit is pending and no falling edge is being detected. A tx_valid pulse while tx_ready is 0 has no effect, so the next cell is a receive cell. An accepted bit clears tx_ready until that bit's cell is over.
- R6: A transmitted 0 gives line_oe=1 and line_out=0 after edges 3 through 14 inclusive, and line_oe=0 in every other cycle.
- R7: A transmitted 1 gives line_oe=1 and line_out=1 after edge 9 only, and line_oe=0 in every other cycle. line_out is never 1 while line_oe is 0.
- R8: A transmit cell produces no rx_valid strobe.
- R9: A new falling edge whose low level is first registered at edge 16 or earlier of a cell is ignored. One first registered at edge 17 or later starts a new cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Pad input level of the debug line |
| line_oe | output | 1 | Pad output enable (1 = target drives) |
| line_out | output | 1 | Pad output value while enabled |
| tx_valid | input | 1 | Offer a bit to return in the next cell |
| tx_bit | input | 1 | Bit value offered with tx_valid |
| tx_ready | output | 1 | Engine idle, an offered bit will be taken |
| rx_valid | output | 1 | One-cycle strobe, received bit available |
| rx_bit | output | 1 | Sampled bit level, valid with rx_valid |

## Verification
The assertions assume a host that starts a cell only with a clean high-to-low transition and holds the line low for at least two clock cycles. They also assume the line is pulled high whenever nobody drives it. The stimulus changes line_in only at falling clock edges, so each level is registered at a known edge number. It models the wire as the host's low drive combined with the target's drive over a pull-up. Extra falling edges are placed only at chosen cycle offsets, to probe the blanking boundary on both sides.

// File: rtl/dbgl_pkg.sv
package dbgl_pkg;

  // True when cnt lies in the inclusive range [lo, hi].
  function automatic logic in_span(input int unsigned cnt,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (cnt >= lo) && (cnt <= hi);
  endfunction

  // Phase of a transmitted 0 during which the line is held low.
  function automatic logic zero_hold(input int unsigned cnt,
                                     input int unsigned zero_end);
    return in_span(cnt, 1, zero_end - 1);
  endfunction

  // Single-cycle phase of the speed-up pulse for a transmitted 1.
  function automatic logic pulse_phase(input int unsigned cnt,
                                       input int unsigned pulse_at);
    return cnt == pulse_at;
  endfunction

endpackage

// File: rtl/dbgl_sync.sv
module dbgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign line_s = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= line_s;
  end

  assign fall = prev & ~line_s;

  // R9
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dbgl_cell_timer.sv
module dbgl_cell_timer #(
  parameter int BLANK     = 16,
  parameter int SAMPLE_AT = 10,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  output logic [CNT_W-1:0] cnt,
  output logic             cell_start,
  output logic             sample_now,
  output logic             idle
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK - 1);

  assign idle       = (cnt == '0);
  assign cell_start = fall & idle;
  assign sample_now = (cnt == CNT_W'(SAMPLE_AT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cell_start)   cnt <= CNT_W'(1);
    else if (cnt == LAST)  cnt <= '0;
    else if (!idle)        cnt <= cnt + CNT_W'(1);
  end

  // R9
  busy_edge_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !idle) |=> cnt != CNT_W'(1));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/dbgl_tx_drive.sv
module dbgl_tx_drive #(
  parameter int PULSE_AT = 7,
  parameter int ZERO_END = 13,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic             tx_bit,
  input  logic             fall,
  input  logic             idle,
  input  logic             cell_start,
  input  logic [CNT_W-1:0] cnt,
  output logic             tx_ready,
  output logic             cell_tx,
  output logic             line_oe,
  output logic             line_out
);
  import dbgl_pkg::*;

  logic pending, pend_bit, cell_bit;
  logic drive_low, speedup;

  assign tx_ready = idle & ~pending & ~fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      pend_bit <= 1'b0;
      cell_tx  <= 1'b0;
      cell_bit <= 1'b0;
    end else if (cell_start) begin
      cell_tx  <= pending;
      cell_bit <= pend_bit;
      pending  <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      pending  <= 1'b1;
      pend_bit <= tx_bit;
    end
  end

  assign drive_low = cell_tx & ~cell_bit & zero_hold(32'(cnt), ZERO_END);
  assign speedup   = cell_tx &  cell_bit & pulse_phase(32'(cnt), PULSE_AT);
  assign line_oe   = drive_low | speedup;
  assign line_out  = speedup;

  // R7
  out_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_out |-> line_oe);

  // R7
  pulse_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && line_out) |=> !line_out);

  // R4
  drive_only_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> cell_tx);

  // R5
  ready_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !cell_start) |=> !tx_ready);
endmodule

// File: rtl/dbgl_bit_engine.sv
module dbgl_bit_engine #(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_AT   = 10,
  parameter int PULSE_AT    = 7,
  parameter int ZERO_END    = 13,
  parameter int BLANK       = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_oe,
  output logic line_out,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready,
  output logic rx_valid,
  output logic rx_bit
);
  localparam int CNT_W = $clog2(BLANK + 1);

  logic             line_s, fall, cell_start, sample_now, idle, cell_tx;
  logic [CNT_W-1:0] cnt;

  dbgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .line_s(line_s), .fall(fall)
  );

  dbgl_cell_timer #(.BLANK(BLANK), .SAMPLE_AT(SAMPLE_AT), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .fall(fall), .cnt(cnt),
    .cell_start(cell_start), .sample_now(sample_now), .idle(idle)
  );

  dbgl_tx_drive #(.PULSE_AT(PULSE_AT), .ZERO_END(ZERO_END), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_bit(tx_bit),
    .fall(fall), .idle(idle), .cell_start(cell_start), .cnt(cnt),
    .tx_ready(tx_ready), .cell_tx(cell_tx),
    .line_oe(line_oe), .line_out(line_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
    end else begin
      rx_valid <= sample_now & ~cell_tx;
      if (sample_now && !cell_tx) rx_bit <= line_s;
    end
  end

  // R2
  rx_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  rx_not_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !line_oe);
endmodule

// File: tb/dbgl_bit_engine_test.sv
module dbgl_bit_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic tx_valid = 1'b0, tx_bit = 1'b0;
  logic line_in, line_oe, line_out, tx_ready, rx_valid, rx_bit;
  int   checks = 0, failures = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  assign line_in = host_low ? 1'b0 : (line_oe ? line_out : 1'b1);

  dbgl_bit_engine uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_oe(line_oe),
    .line_out(line_out), .tx_valid(tx_valid), .tx_bit(tx_bit),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_bit(rx_bit)
  );

  task automatic chk(input string req, input int k, input logic a, input logic e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s k=%0d actual=%0b expected=%0b", req, k, a, e);
    end
  endtask

  // One host cell. k counts negedges; host level set at negedge k is
  // registered at edge k+1. Host drives low for k<lo_len, and optionally
  // starts a second cell (bit 1, low 3 cycles) at k=k2.
  task automatic run_cell(input bit tx, input bit b, input int lo_len,
                          input int k2, input bit poke_busy);
    bit second_ok;
    second_ok = (k2 > 0) && (k2 + 1 >= 17);
    if (tx) begin
      chk("R5", -1, tx_ready, 1'b1);
      tx_valid = 1'b1; tx_bit = b;
      @(negedge clk);
      tx_valid = 1'b0;
      chk("R5", -1, tx_ready, 1'b0);
    end
    for (int k = 0; k <= 48; k++) begin
      logic e_oe, e_out, e_rx;
      e_oe  = tx && (b ? (k == 9) : (k >= 3 && k <= 14));
      e_out = tx && b && (k == 9);
      e_rx  = (!tx && k == 13) || (second_ok && k == k2 + 13);
      chk(tx ? (b ? "R7" : "R6") : "R4", k, line_oe, e_oe);
      if (e_oe) chk(b ? "R7" : "R6", k, line_out, e_out);
      chk(tx ? "R8" : (k2 > 0 ? "R9" : "R2"), k, rx_valid, e_rx);
      if (e_rx) chk("R3", k, rx_bit, (k == 13) ? b : 1'b1);
      if (poke_busy && k == 6) begin
        chk("R5", k, tx_ready, 1'b0);
        tx_valid = 1'b1; tx_bit = 1'b0;
      end else begin
        tx_valid = 1'b0;
      end
      host_low = (k < lo_len) || (k2 > 0 && k >= k2 && k < k2 + 3);
      @(negedge clk);
    end
    host_low = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 0, line_oe, 1'b0);
    chk("R1", 0, rx_valid, 1'b0);
    chk("R1", 0, tx_ready, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", 1, tx_ready, 1'b1);

    // receive sweep: R2 R3 R4
    for (int l = 2; l <= 8; l++) run_cell(1'b0, 1'b1, l, 0, 1'b0);
    for (int l = 12; l <= 14; l++) run_cell(1'b0, 1'b0, l, 0, 1'b0);

    // transmit sweep: R6 R7 R8
    for (int b = 0; b <= 1; b++)
      for (int l = 2; l <= 5; l++) run_cell(1'b1, b[0], l, 0, 1'b0);

    // blanking boundary: R9 (k2=15 -> edge 16 ignored, k2=16 -> edge 17 new)
    run_cell(1'b0, 1'b1, 3, 12, 1'b0);
    run_cell(1'b0, 1'b1, 3, 15, 1'b0);
    run_cell(1'b0, 1'b1, 3, 16, 1'b0);
    run_cell(1'b0, 1'b1, 3, 20, 1'b0);

    // offer while busy has no effect; following cell is receive: R5
    run_cell(1'b0, 1'b1, 3, 0, 1'b1);
    run_cell(1'b0, 1'b1, 3, 0, 1'b0);
    chk("R5", 0, tx_ready, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule